// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus machine cycle for each request from the core of a small 8-bit processor that has a 16-bit address space. The bus shares one set of eight lines between the low address byte and the data byte. The core asks for an opcode fetch, a read or a write, in memory or I/O space, and the sequencer steps through the T-states. It pulses the address strobe, drives the read and write strobes with the correct release timing, and adds wait states while the target holds READY low. It returns the byte it captured, together with a one-clock done pulse.

The block runs from a clock at twice the T-state rate, so every T-state lasts two clocks. The first clock is the first half of the T-state and the second clock is the second half. Events that fall at a half T-state land on ordinary register edges. An opcode fetch can be extended from four to six T-states for instructions that need extra internal time. During those extra states the bus lines hold their previous levels.

Top module: `bus_cycle_seq`

## Requirements
- R1: Status outputs {io_m, s1, s0} are constant for the whole cycle. Opcode fetch gives io_m=0, s1s0=11. Read gives s1s0=10 and write gives s1s0=01, with io_m=1 when req_io is set and 0 otherwise. req_kind encodes fetch=0, read=1, write=2, and 3 runs as a read.
- R2: A T-state lasts two clocks. With no waits, a read or write lasts 3 T-states, an opcode fetch lasts 4, and a fetch with req_long lasts 6. done is high only in the final clock of the cycle, and the block is idle on the next clock.
- R3: ale is high for exactly one clock, the first half of T1, which is the first clock after acceptance. At that time ad_oe=1, ad_out holds the low address byte and a_hi holds the upper byte.
- R4: READY is sampled on the edge that enters T2. Each low sample repeats T2 as one more T-state of two clocks, and READY is sampled again on the edge that enters the repeat.
- R5: For a read or fetch, ad_oe is low from the second half of T1 onward. rd_n is low through all T2 states and the first half of T3. ad_in is captured on the edge that enters T3 and is presented on rdata while done is high.
- R6: For a write, wr_n is low through every T2 state and high from the start of T3. ad_out carries the write data with ad_oe high from the second half of T1 through the first half of T3.
- R7: During T4, T5 and T6 of a fetch, rd_n and wr_n stay high, ale stays low and ad_oe stays low.
- R8: A request is accepted only when the block is idle. req_valid raised during a cycle starts no new cycle and does not change that cycle's address.
- R9: In reset and while idle: busy=0, done=0, rd_n=1, wr_n=1, ale=0, ad_oe=0 and {io_m, s1, s0}=000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_io | input | 1 | I/O space for a read or write |
| req_long | input | 1 | Six-state opcode fetch |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Final clock of the cycle |
| rdata | output | 8 | Captured read byte |
| a_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared lines, outgoing value |
| ad_oe | output | 1 | Output enable of the shared lines |
| ad_in | input | 8 | Shared lines, incoming value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O, 0 for memory |
| s1 | output | 1 | Cycle status, high bit |
| s0 | output | 1 | Cycle status, low bit |
| ready | input | 1 | Target ready, low adds wait states |

## Verification
A wrong T-state or half-phase register shows at the ports within one clock. It moves the ale pulse, shortens or lengthens a strobe by a whole clock, or shifts done away from its expected clock. A miscounted wait sample changes the cycle length by two clocks, and a capture on the wrong edge returns a byte that does not match the bench's address-derived memory. A status register that is loaded at the wrong time shows up as status bits changing in the middle of a cycle or staying set while idle.

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic                     req_io,
  input  logic                     req_long,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  input  logic                     ready
);
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam logic [2:0] T_IDLE  = 3'd0;

  logic [2:0]        t_q;
  logic              h_q;
  logic              wait_q;
  logic [1:0]        kind_q;
  logic              io_q;
  logic              long_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rdata_q;

  logic       is_fetch, is_wr, is_rd, t1, t2, t3;
  logic [2:0] last_t;

  assign is_fetch = kind_q == K_FETCH;
  assign is_wr    = kind_q == K_WRITE;
  assign is_rd    = !is_wr;
  assign last_t   = is_fetch ? (long_q ? 3'd6 : 3'd4) : 3'd3;
  assign t1       = t_q == 3'd1;
  assign t2       = t_q == 3'd2;
  assign t3       = t_q == 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q     <= T_IDLE;
      h_q     <= 1'b0;
      wait_q  <= 1'b0;
      kind_q  <= K_FETCH;
      io_q    <= 1'b0;
      long_q  <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      rdata_q <= '0;
    end else if (t_q == T_IDLE) begin
      if (req_valid) begin
        t_q    <= 3'd1;
        h_q    <= 1'b0;
        kind_q <= req_kind;
        io_q   <= req_io;
        long_q <= req_long;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
      end
    end else if (!h_q) begin
      h_q <= 1'b1;
    end else begin
      h_q <= 1'b0;
      if (t2 && wait_q) begin
        wait_q <= !ready;
      end else if (t_q == last_t) begin
        t_q <= T_IDLE;
      end else begin
        t_q <= t_q + 3'd1;
        if (t1) wait_q <= !ready;
        if (t2 && is_rd) rdata_q <= ad_in;
      end
    end
  end

  assign busy   = t_q != T_IDLE;
  assign done   = busy && h_q && (t_q == last_t);
  assign rdata  = rdata_q;
  assign a_hi   = addr_q[ADDR_W-1:DATA_W];
  assign ale    = t1 && !h_q;
  assign ad_oe  = (t1 && !h_q) || (is_wr && (t1 || t2 || (t3 && !h_q)));
  assign ad_out = (t1 && !h_q) ? addr_q[DATA_W-1:0] : wd_q;
  assign rd_n   = !(is_rd && (t2 || (t3 && !h_q)));
  assign wr_n   = !(is_wr && t2);
  assign io_m   = busy && io_q && !is_fetch;
  assign s1     = busy && is_rd;
  assign s0     = busy && (is_fetch || is_wr);
endmodule

module bus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic io_m,
  input logic s1,
  input logic s0
);
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({io_m, s1, s0})); // R1
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done)); // R2
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R3
  AST_RD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R5
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && rd_n)); // R6
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> ale); // R8
  AST_NO_MIDCYCLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !ale); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && !ale && !ad_oe && !io_m && !s1 && !s0 && !done)); // R9
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .io_m(io_m), .s1(s1), .s0(s0)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic req_io = 1'b0, req_long = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, ad_oe, ale, rd_n, wr_n, io_m, s1, s0;
  logic ready = 1'b1;
  logic [7:0] rdata, a_hi, ad_out, ad_in;
  logic [15:0] lat_addr = '0;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign ad_in = rd_n ? 8'h00 : mem_f(lat_addr);

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_io(req_io), .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .a_hi(a_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] kind, input logic io, input logic lng,
                     input logic [15:0] addr, input logic [7:0] wd,
                     input int dly, input bit intrude);
    int k = 0, kdone = -1, ale_n = 0, rd_lo = 0, wr_lo = 0, oe_n = 0, st_bad = 0;
    int n, w, exp_len;
    bit prev_wr = 1'b1, hold_ok = 1'b1, hold_seen = 1'b0;
    logic [2:0] exp_st;
    exp_st = {io && kind != 2'd0, kind != 2'd2, kind == 2'd0 || kind == 2'd2};
    n = (kind == 2'd0) ? (lng ? 6 : 4) : 3;
    w = dly / 2;
    exp_len = 2 * n - 1 + 2 * w;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_io = io; req_long = lng;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = intrude;
    if (intrude) req_addr = ~addr;
    ready = (dly == 0);
    while (kdone < 0 && k < 200) begin
      if (k == dly && dly > 0) ready = 1'b1;
      if (k == 5 && intrude) req_valid = 1'b0;
      if ({io_m, s1, s0} != exp_st) st_bad++;
      if (ale) begin
        ale_n++;
        lat_addr = {a_hi, ad_out};
        chk(ad_oe && k == 0, "R3", "ale timing/oe", k, 0);
      end
      if (!rd_n) rd_lo++;
      if (!wr_n) wr_lo++;
      if (ad_oe) oe_n++;
      if (!prev_wr && wr_n) begin
        hold_seen = 1'b1;
        if (!(ad_oe && ad_out == wd)) hold_ok = 1'b0;
      end
      prev_wr = wr_n;
      if (done) kdone = k;
      else begin @(negedge clk); k++; end
    end
    chk(kdone == exp_len, (dly > 1) ? "R4" : "R2", "done clock", kdone, exp_len);
    chk(st_bad == 0, "R1", "status mismatches", st_bad, 0);
    chk(ale_n == 1 && lat_addr == addr, "R3", "latched address", lat_addr, addr);
    if (kind != 2'd2) begin
      chk(rd_lo == 3 + 2 * w, (kind == 2'd0) ? "R7" : "R5", "rd_n low clocks", rd_lo, 3 + 2 * w);
      chk(oe_n == 1, "R5", "oe clocks", oe_n, 1);
      chk(rdata == mem_f(addr), "R5", "rdata", rdata, mem_f(addr));
      chk(wr_lo == 0, "R7", "wr_n low clocks", wr_lo, 0);
    end else begin
      chk(wr_lo == 2 + 2 * w, "R6", "wr_n low clocks", wr_lo, 2 + 2 * w);
      chk(oe_n == 5 + 2 * w, "R6", "oe clocks", oe_n, 5 + 2 * w);
      chk(hold_seen && hold_ok, "R6", "data hold after wr_n", ad_out, wd);
      chk(rd_lo == 0, "R6", "rd_n low clocks", rd_lo, 0);
    end
    @(negedge clk);
    chk(!busy && rd_n && wr_n && !ale && !ad_oe && {io_m, s1, s0} == 3'b000,
        "R9", "idle quiet", {busy, io_m, s1, s0}, 0);
    if (intrude) begin
      for (int i = 0; i < 4; i++) begin
        chk(!busy && !ale, "R8", "no start from mid-cycle request", {busy, ale}, 0);
        @(negedge clk);
      end
    end
    ready = 1'b1;
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic        io;
    logic        lng;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [3:0]  dly;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 16'h1200, 8'h00, 4'd0},
    {2'd1, 1'b0, 1'b0, 16'h1201, 8'h00, 4'd0},
    {2'd1, 1'b0, 1'b0, 16'h3400, 8'h00, 4'd3},
    {2'd1, 1'b0, 1'b0, 16'h3401, 8'h00, 4'd6},
    {2'd2, 1'b0, 1'b0, 16'h4455, 8'h3C, 4'd0},
    {2'd2, 1'b1, 1'b0, 16'h8181, 8'hC3, 4'd5},
    {2'd1, 1'b1, 1'b0, 16'h2020, 8'h00, 4'd2},
    {2'd0, 1'b0, 1'b1, 16'h0100, 8'h00, 4'd4},
    {2'd0, 1'b1, 1'b0, 16'h0200, 8'h00, 4'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && rd_n && wr_n && !ale && !ad_oe && {io_m, s1, s0} == 3'b000,
        "R9", "reset state", {busy, done, ale, ad_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      run(VEC[i].kind, VEC[i].io, VEC[i].lng, VEC[i].addr, VEC[i].wd, int'(VEC[i].dly), 1'b0);
    // R8: request raised during a fetch is ignored
    run(2'd0, 1'b0, 1'b0, 16'h7788, 8'h00, 0, 1'b1);
    // R4: two-byte operand, low byte first, random wait states
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a;
      a = 16'h5000 + 16'(i * 16'h0111);
      run(2'd1, 1'b0, 1'b0, a, 8'h00, int'($urandom_range(0, 9)), 1'b0);
      run(2'd1, 1'b0, 1'b0, a + 16'd1, 8'h00, int'($urandom_range(0, 9)), 1'b0);
    end
    // R1: kind 3 runs as a read with read status
    run(2'd3, 1'b1, 1'b0, 16'h9A9B, 8'h00, 2, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule